// File: doc/BRIEF.md
# Variable-Size Register Window Stack

This block fronts a processor register file. It treats a bank of local registers as a circular procedure stack and keeps a separate bank of global registers that is always addressable. Each call request carries a size, and the block opens a new window of exactly that many local registers on top of the caller's window. A return releases the window and makes the caller's window current again. Local registers are addressed by an offset from the current window base, and the offset wraps modulo the bank size.

The local bank is smaller than the total stack. When a call would need more local registers than are free, the oldest words on the stack are written out, one at a time, to a memory-resident stack through a request/acknowledge port. The memory address of a word is its absolute depth in the stack. When a return would uncover words that were written out, those words are read back into the bank before the block accepts register accesses again. While words are moving, a busy flag is high and the block ignores register accesses, calls and returns.

Because no register is reserved as a condition-code register, a comparison result is stored in an ordinary window or global register, and nothing extra has to be saved across a call.

Top module: `rws_stack`

## Requirements
- R1: The global bank holds 64 registers. A register address with bit 7 set selects global register bits[5:0]. The same global register is seen from every window depth.
- R2: A register address with bit 7 clear selects local offset bits[6:0] of the current window, at slot (base + offset) mod 128. A call places the new window base at the current top of stack. A return restores the caller's base, and the caller's register values are unchanged.
- R3: A call of size n takes exactly n local registers. Words are written out only when the resident words plus n exceed 128, and then exactly that excess is written. The oldest word goes first, to memory address equal to its absolute stack depth, in ascending order.
- R4: A return reads back every written-out word of the caller's window, in descending address order, before busy falls. After that, every register of the caller's window reads its old value.
- R5: Each memory handshake moves one 32-bit word. mem_req stays high with a stable mem_addr and mem_we until mem_ack. mem_we is 1 when a word is written out and 0 when a word is read back.
- R6: busy is high from the edge that accepts a call or return needing transfers until the last transfer completes. While busy is high, register writes, reads, calls and returns have no effect.
- R7: A call with a size greater than 128 pulses err for one cycle. It changes neither the window nor any register.
- R8: A return with no open frame pulses err and has no effect. A call when 16 frames are already open also pulses err and has no effect.
- R9: A read accepted on one clock edge presents its data on rd_data after that edge, one cycle of latency.
- R10: After a synchronous reset, busy, err and mem_req are 0. The stack is empty, with the window base at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| call_en | input | 1 | Open a new window (takes priority over ret_en) |
| call_size | input | 8 | Number of local registers requested |
| ret_en | input | 1 | Close the current window |
| rd_en | input | 1 | Register read request |
| rd_addr | input | 8 | Read address: bit 7 global select, low bits index/offset |
| rd_data | output | 32 | Read data, valid the cycle after an accepted read |
| wr_en | input | 1 | Register write request |
| wr_addr | input | 8 | Write address, same encoding as rd_addr |
| wr_data | input | 32 | Write data |
| busy | output | 1 | Words are moving to or from memory |
| err | output | 1 | One-cycle pulse on a rejected call or return |
| mem_req | output | 1 | Memory transfer request |
| mem_we | output | 1 | 1 = write a word out, 0 = read a word back |
| mem_addr | output | 12 | Memory stack word address |
| mem_wdata | output | 32 | Word being written out |
| mem_rdata | input | 32 | Word read back, valid with mem_ack |
| mem_ack | input | 1 | One-cycle completion of the current transfer |

## Verification
The assertions assume a memory that raises mem_ack for a single cycle, and only while mem_req is high. They also assume that the controller never asks the frame LIFO to pop when it is empty or to push when it is full. The bench memory answers with a rotating delay of zero to two cycles and never acknowledges twice in a row without a fresh request. The bench never raises call_en and ret_en together, and it stays within 16 open frames except in the one call that tests rejection.

// File: rtl/rws_pkg.sv
package rws_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SPILL_RD,
    ST_SPILL_REQ,
    ST_FILL_REQ
  } rws_state_e;
endpackage

// File: rtl/rws_ram.sv
module rws_ram #(
  parameter int DEPTH = 128,
  parameter int W     = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(DEPTH)-1:0] waddr,
  input  logic [W-1:0]             wdata,
  input  logic                     re,
  input  logic [$clog2(DEPTH)-1:0] raddr,
  output logic [W-1:0]             rdata
);
  logic [W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    if (re) rdata <= cells[raddr];
  end
endmodule

// File: rtl/rws_frame_lifo.sv
module rws_frame_lifo #(
  parameter int DEPTH = 16,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic         pop,
  input  logic [W-1:0] push_data,
  output logic [W-1:0] top,
  output logic         full,
  output logic         empty
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam int IW = $clog2(DEPTH);

  logic [W-1:0]  slots [DEPTH];
  logic [CW-1:0] cnt;

  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);
  assign top   = slots[IW'(cnt - CW'(1))];

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (push && !full) begin
      slots[IW'(cnt)] <= push_data;
      cnt <= cnt + CW'(1);
    end else if (pop && !empty) begin
      cnt <= cnt - CW'(1);
    end
  end

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    push |-> !full);
  assert_no_underflow_R8: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/rws_stack.sv
module rws_stack
  import rws_pkg::*;
#(
  parameter int LOCAL_REGS  = 128,
  parameter int GLOBAL_REGS = 64,
  parameter int DATA_W      = 32,
  parameter int MAX_FRAMES  = 16
) (
  input  logic                                           clk,
  input  logic                                           rst,
  input  logic                                           call_en,
  input  logic [$clog2(LOCAL_REGS):0]                    call_size,
  input  logic                                           ret_en,
  input  logic                                           rd_en,
  input  logic [$clog2(LOCAL_REGS):0]                    rd_addr,
  output logic [DATA_W-1:0]                              rd_data,
  input  logic                                           wr_en,
  input  logic [$clog2(LOCAL_REGS):0]                    wr_addr,
  input  logic [DATA_W-1:0]                              wr_data,
  output logic                                           busy,
  output logic                                           err,
  output logic                                           mem_req,
  output logic                                           mem_we,
  output logic [$clog2(MAX_FRAMES*LOCAL_REGS+1)-1:0]     mem_addr,
  output logic [DATA_W-1:0]                              mem_wdata,
  input  logic [DATA_W-1:0]                              mem_rdata,
  input  logic                                           mem_ack
);
  localparam int LA_W  = $clog2(LOCAL_REGS);
  localparam int GA_W  = $clog2(GLOBAL_REGS);
  localparam int SZ_W  = LA_W + 1;
  localparam int TOT_W = $clog2(MAX_FRAMES * LOCAL_REGS + 1);
  localparam logic [SZ_W-1:0]  MAX_SZ  = SZ_W'(LOCAL_REGS);
  localparam logic [TOT_W-1:0] LOCAL_T = TOT_W'(LOCAL_REGS);

  rws_state_e       state;
  logic [TOT_W-1:0] total, spilled, base;
  logic [SZ_W-1:0]  cur_size, caller_size;
  logic             lifo_full, lifo_empty;
  logic             call_ok, call_bad, ret_ok, ret_bad;
  logic [TOT_W-1:0] new_total, new_base, spill_next, fill_next;
  logic             rd_sel_q;

  logic             l_we, l_re, g_we, g_re;
  logic [LA_W-1:0]  l_waddr, l_raddr;
  logic [DATA_W-1:0] l_wdata, l_q, g_q;

  assign busy = (state != ST_IDLE);

  always_comb begin
    call_bad   = call_en && !busy && ((call_size > MAX_SZ) || lifo_full);
    call_ok    = call_en && !busy && !call_bad;
    ret_bad    = ret_en && !call_en && !busy && lifo_empty;
    ret_ok     = ret_en && !call_en && !busy && !lifo_empty;
    new_total  = total + TOT_W'(call_size);
    new_base   = base - TOT_W'(caller_size);
    spill_next = spilled + TOT_W'(1);
    fill_next  = spilled - TOT_W'(1);
    mem_addr   = (state == ST_FILL_REQ) ? fill_next : spilled;
  end

  // Local bank port steering: transfers own the bank while busy.
  always_comb begin
    l_we    = (state == ST_FILL_REQ && mem_ack) || (wr_en && !busy && !wr_addr[LA_W]);
    l_waddr = (state == ST_FILL_REQ) ? fill_next[LA_W-1:0]
                                     : base[LA_W-1:0] + wr_addr[LA_W-1:0];
    l_wdata = (state == ST_FILL_REQ) ? mem_rdata : wr_data;
    l_re    = (state == ST_SPILL_RD) || (rd_en && !busy && !rd_addr[LA_W]);
    l_raddr = (state == ST_SPILL_RD) ? spilled[LA_W-1:0]
                                     : base[LA_W-1:0] + rd_addr[LA_W-1:0];
    g_we    = wr_en && !busy && wr_addr[LA_W];
    g_re    = rd_en && !busy && rd_addr[LA_W];
  end

  rws_ram #(.DEPTH(LOCAL_REGS), .W(DATA_W)) u_local (
    .clk(clk), .we(l_we), .waddr(l_waddr), .wdata(l_wdata),
    .re(l_re), .raddr(l_raddr), .rdata(l_q)
  );

  rws_ram #(.DEPTH(GLOBAL_REGS), .W(DATA_W)) u_global (
    .clk(clk), .we(g_we), .waddr(wr_addr[GA_W-1:0]), .wdata(wr_data),
    .re(g_re), .raddr(rd_addr[GA_W-1:0]), .rdata(g_q)
  );

  rws_frame_lifo #(.DEPTH(MAX_FRAMES), .W(SZ_W)) u_frames (
    .clk(clk), .rst(rst), .push(call_ok), .pop(ret_ok),
    .push_data(cur_size), .top(caller_size),
    .full(lifo_full), .empty(lifo_empty)
  );

  assign rd_data   = rd_sel_q ? g_q : l_q;
  assign mem_wdata = l_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_IDLE;
      total    <= '0;
      spilled  <= '0;
      base     <= '0;
      cur_size <= '0;
      err      <= 1'b0;
      mem_req  <= 1'b0;
      mem_we   <= 1'b0;
      rd_sel_q <= 1'b0;
    end else begin
      err <= call_bad || ret_bad;
      if (rd_en && !busy) rd_sel_q <= rd_addr[LA_W];
      case (state)
        ST_IDLE: begin
          if (call_ok) begin
            base     <= total;
            cur_size <= call_size;
            total    <= new_total;
            if (new_total - spilled > LOCAL_T) state <= ST_SPILL_RD;
          end else if (ret_ok) begin
            total    <= base;
            base     <= new_base;
            cur_size <= caller_size;
            if (spilled > new_base) begin
              state   <= ST_FILL_REQ;
              mem_req <= 1'b1;
              mem_we  <= 1'b0;
            end
          end
        end
        ST_SPILL_RD: begin
          state   <= ST_SPILL_REQ;
          mem_req <= 1'b1;
          mem_we  <= 1'b1;
        end
        ST_SPILL_REQ: begin
          if (mem_ack) begin
            spilled <= spill_next;
            mem_req <= 1'b0;
            state   <= (total - spill_next > LOCAL_T) ? ST_SPILL_RD : ST_IDLE;
          end
        end
        ST_FILL_REQ: begin
          if (mem_ack) begin
            spilled <= fill_next;
            if (fill_next <= base) begin
              mem_req <= 1'b0;
              state   <= ST_IDLE;
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_resident_fits_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> ((total - spilled) <= LOCAL_T));
  assert_fill_complete_R4: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE) |-> (spilled <= base));
  assert_req_held_R5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));
  assert_req_busy_R6: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> busy);
  assert_err_nochange_R7: assert property (@(posedge clk) disable iff (rst)
    err |-> (total == $past(total) && base == $past(base)));
endmodule

// File: tb/rws_stack_tb.sv
module rws_stack_tb;
  localparam int LR = 128, GR = 64, DW = 32, MF = 16;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, call_en, ret_en, rd_en, wr_en, busy, err, mem_req, mem_we, mem_ack;
  logic [7:0]  call_size, rd_addr, wr_addr;
  logic [31:0] rd_data, wr_data, mem_wdata, mem_rdata;
  logic [11:0] mem_addr;

  rws_stack #(.LOCAL_REGS(LR), .GLOBAL_REGS(GR), .DATA_W(DW), .MAX_FRAMES(MF)) u_dut (
    .clk(clk), .rst(rst), .call_en(call_en), .call_size(call_size), .ret_en(ret_en),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .busy(busy), .err(err),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_ack(mem_ack)
  );

  logic [31:0] mem      [0:2047];
  logic [31:0] ref_word [0:2047];
  logic [31:0] ref_glob [0:63];
  int n_chk = 0, n_fail = 0;
  int m_base = 0, m_size = 0, m_total = 0, m_spilled = 0, hs_cnt = 0;
  int size_q[$];
  bit mon_on = 0, prev_pend = 0, exp_we = 0;
  logic [11:0] prev_addr;
  int lat = 0, dly = 0;

  task automatic check(bit ok, string tag, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Memory model: one-cycle ack after a rotating 0..2 cycle delay.
  always @(posedge clk) begin
    mem_ack <= 1'b0;
    if (rst) begin
      lat <= 0;
    end else if (mem_req && !mem_ack) begin
      if (lat >= dly) begin
        mem_ack <= 1'b1;
        lat <= 0;
        dly <= (dly + 1) % 3;
        if (mem_we) mem[int'(mem_addr)] <= mem_wdata;
        else mem_rdata <= mem[int'(mem_addr)];
      end else begin
        lat <= lat + 1;
      end
    end
  end

  // Per-cycle comparison of the memory port against the reference model.
  always @(negedge clk) begin
    if (mon_on) begin
      if (prev_pend) begin
        check(mem_req === 1'b1, "R5 req held", mem_req, 1);
        check(mem_addr === prev_addr, "R5 addr stable", mem_addr, prev_addr);
      end
      if (mem_req) check(busy === 1'b1, "R6 busy with req", busy, 1);
      if (mem_req && mem_ack) begin
        hs_cnt++;
        check(mem_we === exp_we, "R5 direction", mem_we, exp_we);
        if (exp_we) begin
          check(int'(mem_addr) == m_spilled, "R3 spill addr", mem_addr, m_spilled);
          check(mem_wdata === ref_word[m_spilled], "R3 spill data",
                mem_wdata, ref_word[m_spilled]);
          m_spilled++;
        end else begin
          check(int'(mem_addr) == m_spilled - 1, "R4 fill addr", mem_addr, m_spilled - 1);
          m_spilled--;
        end
      end
      prev_pend = mem_req && !mem_ack;
      prev_addr = mem_addr;
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
    if (a[7]) ref_glob[a[5:0]] = d; else ref_word[m_base + int'(a[6:0])] = d;
  endtask

  task automatic rd_check(logic [7:0] a, string tag);
    logic [31:0] e;
    e = a[7] ? ref_glob[a[5:0]] : ref_word[m_base + int'(a[6:0])];
    @(negedge clk); rd_en = 1; rd_addr = a;
    @(negedge clk); rd_en = 0;
    check(rd_data === e, tag, rd_data, e);
  endtask

  task automatic fill_frame(int fid);
    for (int r = 0; r < m_size; r++) wr_reg(8'(r), (fid << 16) | r);
  endtask

  task automatic verify_frame(string tag);
    for (int r = 0; r < m_size; r++) rd_check(8'(r), tag);
  endtask

  task automatic do_call(int n, bit poke, int exp_hs);
    bit e_err;
    int e_sp;
    e_err = (n > LR) || (size_q.size() >= MF);
    e_sp  = e_err ? 0 : ((m_total - m_spilled + n > LR) ? (m_total - m_spilled + n - LR) : 0);
    if (exp_hs >= 0) check(e_sp == exp_hs, "R3 model spill count", e_sp, exp_hs);
    hs_cnt = 0; exp_we = 1;
    @(negedge clk); call_en = 1; call_size = 8'(n);
    @(negedge clk); call_en = 0;
    check(err === e_err, e_err ? "R7/R8 err on bad call" : "R7 no err", err, e_err);
    check(busy === (e_sp > 0), "R6 busy after call", busy, e_sp > 0);
    if (poke && busy) begin
      wr_en = 1; wr_addr = 8'h85; wr_data = 32'hDEAD_0005;
      @(negedge clk); wr_en = 0;
    end
    while (busy) @(negedge clk);
    check(hs_cnt == e_sp, "R3 spill words", hs_cnt, e_sp);
    if (!e_err) begin
      size_q.push_back(m_size);
      m_base = m_total; m_size = n; m_total += n;
    end
  endtask

  task automatic do_ret(int exp_hs);
    bit e_err;
    int prev, nb, e_fl;
    e_err = (size_q.size() == 0);
    prev  = e_err ? 0 : size_q[$];
    nb    = m_base - prev;
    e_fl  = (!e_err && m_spilled > nb) ? (m_spilled - nb) : 0;
    if (exp_hs >= 0) check(e_fl == exp_hs, "R4 model fill count", e_fl, exp_hs);
    hs_cnt = 0; exp_we = 0;
    @(negedge clk); ret_en = 1;
    @(negedge clk); ret_en = 0;
    check(err === e_err, e_err ? "R8 err on empty return" : "R8 no err", err, e_err);
    check(busy === (e_fl > 0), "R6 busy after return", busy, e_fl > 0);
    while (busy) @(negedge clk);
    check(hs_cnt == e_fl, "R4 fill words", hs_cnt, e_fl);
    if (!e_err) begin
      void'(size_q.pop_back());
      m_total = m_base; m_base = nb; m_size = prev;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1; call_en = 0; ret_en = 0; rd_en = 0; wr_en = 0;
    call_size = 0; rd_addr = 0; wr_addr = 0; wr_data = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    mon_on = 1;
    // R10: reset state
    check(busy === 1'b0, "R10 busy", busy, 0);
    check(err === 1'b0, "R10 err", err, 0);
    check(mem_req === 1'b0, "R10 mem_req", mem_req, 0);

    // R1: global bank
    wr_reg(8'h80, 32'h1111_0000);
    wr_reg(8'hBF, 32'h1111_003F);
    wr_reg(8'h85, 32'h1111_0005);
    rd_check(8'h80, "R1 global 0");
    rd_check(8'hBF, "R1 global 63");

    // R2/R9: small window at base 0
    do_call(2, 0, 0);
    fill_frame(1);
    rd_check(8'h00, "R9 read latency r0");
    verify_frame("R2 window 2");
    do_call(100, 0, 0);
    fill_frame(2);
    do_call(26, 0, 0);            // exactly fills the bank: no transfer (R3)
    fill_frame(3);
    rd_check(8'hBF, "R1 global seen from depth 3");
    do_call(5, 1, 5);             // excess 5 words, poke a write while busy (R6)
    fill_frame(4);
    rd_check(8'h85, "R6 write during busy ignored");
    do_call(120, 0, 120);
    fill_frame(5);
    do_call(129, 0, 0);           // R7 rejected
    rd_check(8'h00, "R7 window unchanged");
    rd_check(8'h77, "R7 window unchanged top");

    // R4: unwind with fills
    do_ret(0);
    verify_frame("R4 frame 5 regs");
    do_ret(23);
    verify_frame("R4 frame 26 regs");
    do_ret(100);
    verify_frame("R4 frame 100 regs");
    do_ret(2);
    verify_frame("R2 frame 2 regs");
    do_ret(0);
    do_ret(0);                    // R8 empty return
    check(m_total == 0 && m_spilled == 0, "R8 model at root", m_total, 0);

    // R8: frame depth limit
    for (int i = 0; i < MF; i++) do_call(3, 0, 0);
    do_call(3, 0, 0);             // 17th rejected
    for (int i = 0; i < MF; i++) do_ret(0);
    rd_check(8'hBF, "R1 global after unwind");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule